// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block sits between a synchronous host and an external 32K x 16 asynchronous static RAM that has separate strobes for its lower and upper byte. The host hands over one request at a time on a valid/ready port. Each request carries a read/write flag, a 15-bit word address, 16 bits of write data and a 2-bit byte mask. The sequencer turns each request into a timed pattern on the memory's chip enable, output enable, write enable and byte strobe pins. It also drives the write data together with a separate drive-enable for the data bus, because the pad tri-state cell sits outside this block.

Every phase of the pattern lasts a whole number of clock cycles. These counts are computed at elaboration from the clock period (in picoseconds) and the memory's speed grade (10, 12, 15 or 20 ns), so one parameter change retargets the block. A write only puts data on the bus once output enable has been high long enough for the memory to release it. The write ends when write enable rises, and address, data, chip enable and byte strobes are all held for one more cycle after that edge. For a read, the word is latched once the access count has run out and handed back with a one-cycle valid pulse.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_bs_n` is 2'b11, and both `mem_dq_oe` and `rd_valid` are 0.
- R2: A write whose mask is nonzero lowers `mem_we_n` once, for at least ceil(write-pulse minimum / clock period) cycles. While `mem_we_n` is low, `mem_ce_n` is low and `mem_bs_n` equals the inverted mask. Strobes are active low, mask bit 0 controls `mem_bs_n[0]` (lower byte, data bits 7:0) and mask bit 1 controls `mem_bs_n[1]` (upper byte, data bits 15:8).
- R3: When `mem_we_n` rises, the address has been steady with chip enable low for at least ceil(address-valid-to-write-end / period) cycles. The data has been driven and steady for at least ceil(data-setup / period) cycles. In the cycle after the rise, address, data, drive enable, chip enable and byte strobes are all unchanged.
- R4: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. When `mem_dq_oe` rises, `mem_oe_n` has already been 1 for at least ceil(output-float time / period) cycles.
- R5: A write with mask 2'b00 leaves `mem_we_n` and `mem_bs_n` inactive, leaves the memory contents unchanged, and still completes with the usual busy time.
- R6: During a read, `mem_ce_n` and `mem_oe_n` are 0, `mem_bs_n` is 2'b00, `mem_we_n` is 1 and `mem_dq_oe` is 0. If the request is accepted at clock edge E, `rd_valid` is 1 for exactly one cycle, the one following edge E+ACCESS, where ACCESS = ceil(grade ns / period).
- R7: After a request is accepted, `req_ready` stays low for exactly max(cycle-time count, phase count of that access) cycles. The cycle-time count is ceil(grade ns / period). The phase count is FLOAT+PULSE+1 for a masked write, ACCESS for a read and 0 for an all-zero-mask write.
- R8: `rd_data` equals the word last written at that address, where each byte comes from the most recent write whose mask bit for that byte was set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle; a request is taken on this cycle's edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte mask for writes, bit 0 = lower byte |
| rd_valid | output | 1 | One-cycle pulse, read data available |
| rd_data | output | 16 | Captured read word |
| mem_addr | output | 15 | Memory address pins |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bs_n | output | 2 | Byte strobes, active low, bit 0 = lower byte |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_in | input | 16 | Data from the memory pads |

## Verification
The bench builds the block at its defaults: a 4000 ps clock and the 10 ns grade. That gives a float count of 2, a write pulse of 2, an access count of 3 and a cycle-time count of 3. With these values a masked write outlasts the cycle-time floor while a zero-mask write and a read sit exactly on it, so both branches of the busy-time rule are exercised. Every mask value is swept over 64 low addresses, and back-to-back reads and writes at the top of the address space put the read-to-write turnaround on the float window. A behavioural memory in the bench stores data only on the edge where write enable rises, so a wrong strobe or a wrong data byte shows up in a later read.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WSETUP,
      ST_WPULSE,
      ST_WHOLD,
      ST_RACCESS,
      ST_TAIL
   } phase_e;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // minimum write-enable low time, ps
   function automatic int pwe_ps(input int grade);
      case (grade)
         10:      return 7000;
         12:      return 8000;
         15:      return 10000;
         default: return 11000;
      endcase
   endfunction

   // minimum data setup to end of write, ps
   function automatic int dsetup_ps(input int grade);
      case (grade)
         10:      return 5000;
         12:      return 6000;
         15:      return 7000;
         default: return 8000;
      endcase
   endfunction

   // minimum address valid to end of write, ps
   function automatic int awin_ps(input int grade);
      case (grade)
         10:      return 9000;
         12:      return 10000;
         15:      return 11000;
         default: return 12000;
      endcase
   endfunction

   // maximum time for the memory to float its outputs, ps
   function automatic int float_ps(input int grade);
      case (grade)
         10:      return 5000;
         12:      return 6000;
         15:      return 7000;
         default: return 8000;
      endcase
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (load)            cnt_q <= load_val;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_byte_lanes.sv
module sram_byte_lanes #(
   parameter int LANES = 2
) (
   input  logic             active,
   input  logic             wr,
   input  logic [LANES-1:0] mask,
   output logic [LANES-1:0] strobe_n
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      // reads open every lane, writes only the masked ones
      assign strobe_n[i] = ~(active & (~wr | mask[i]));
   end

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int   ADDR_W   = 15,
   parameter int   DATA_W   = 16,
   parameter int   LANE_W   = 8,
   parameter int   GRADE_NS = 10,
   parameter int   CLK_PS   = 4000,
   localparam int  LANES    = DATA_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_mask,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [LANES-1:0]  mem_bs_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   // phase lengths in cycles, derived from the grade limits
   localparam int FLOAT_CYC  = max2(1, ceil_div(float_ps(GRADE_NS), CLK_PS));
   localparam int PULSE_CYC  = max2(max2(ceil_div(pwe_ps(GRADE_NS), CLK_PS),
                                         ceil_div(dsetup_ps(GRADE_NS), CLK_PS)),
                                    ceil_div(awin_ps(GRADE_NS), CLK_PS) - FLOAT_CYC);
   localparam int HOLD_CYC   = 1;
   localparam int ACCESS_CYC = max2(1, ceil_div(GRADE_NS * 1000, CLK_PS));
   localparam int CYCLE_CYC  = max2(1, ceil_div(GRADE_NS * 1000, CLK_PS));
   localparam int MAX_CYC    = max2(max2(FLOAT_CYC, PULSE_CYC), max2(ACCESS_CYC, CYCLE_CYC));
   localparam int CNT_W      = max2(1, $clog2(MAX_CYC + 1));

   initial begin
      assert (DATA_W % LANE_W == 0 && LANES >= 1)
         else $fatal(1, "data width must be a whole number of lanes");
      assert (GRADE_NS == 10 || GRADE_NS == 12 || GRADE_NS == 15 || GRADE_NS == 20)
         else $fatal(1, "unsupported speed grade");
      assert (CLK_PS > 0) else $fatal(1, "clock period must be positive");
   end

   phase_e           st_q, st_d;
   logic             accept;
   logic             ph_load, ph_exp, cyc_exp;
   logic [CNT_W-1:0] ph_val;
   logic [LANES-1:0] mask_q, mask_sel;
   logic             lane_active, lane_wr;
   logic [LANES-1:0] bs_n_d;

   assign req_ready = (st_q == ST_IDLE);
   assign accept    = req_valid && req_ready;

   sram_phase_timer #(.CNT_W(CNT_W)) u_ph_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ph_load),
      .load_val (ph_val),
      .expired  (ph_exp)
   );

   sram_phase_timer #(.CNT_W(CNT_W)) u_cyc_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (CNT_W'(CYCLE_CYC - 1)),
      .expired  (cyc_exp)
   );

   always_comb begin
      st_d    = st_q;
      ph_load = 1'b0;
      ph_val  = '0;
      case (st_q)
         ST_IDLE: if (req_valid) begin
            if (!req_write) begin
               st_d = ST_RACCESS; ph_load = 1'b1; ph_val = CNT_W'(ACCESS_CYC - 1);
            end else if (|req_mask) begin
               st_d = ST_WSETUP;  ph_load = 1'b1; ph_val = CNT_W'(FLOAT_CYC - 1);
            end else begin
               st_d = ST_TAIL;
            end
         end
         ST_WSETUP: if (ph_exp) begin
            st_d = ST_WPULSE; ph_load = 1'b1; ph_val = CNT_W'(PULSE_CYC - 1);
         end
         ST_WPULSE: if (ph_exp) begin
            st_d = ST_WHOLD;  ph_load = 1'b1; ph_val = CNT_W'(HOLD_CYC - 1);
         end
         ST_WHOLD, ST_RACCESS: if (ph_exp) st_d = cyc_exp ? ST_IDLE : ST_TAIL;
         ST_TAIL:  if (cyc_exp) st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   assign mask_sel    = accept ? req_mask : mask_q;
   assign lane_active = (st_d == ST_WSETUP) || (st_d == ST_WPULSE) ||
                        (st_d == ST_WHOLD)  || (st_d == ST_RACCESS);
   assign lane_wr     = (st_d != ST_RACCESS);

   sram_byte_lanes #(.LANES(LANES)) u_lanes (
      .active   (lane_active),
      .wr       (lane_wr),
      .mask     (mask_sel),
      .strobe_n (bs_n_d)
   );

   // strobes come straight from flops so the pins never see decode glitches
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         mask_q     <= '0;
         mem_addr   <= '0;
         mem_dq_out <= '0;
         mem_ce_n   <= 1'b1;
         mem_oe_n   <= 1'b1;
         mem_we_n   <= 1'b1;
         mem_bs_n   <= '1;
         mem_dq_oe  <= 1'b0;
         rd_valid   <= 1'b0;
         rd_data    <= '0;
      end else begin
         st_q      <= st_d;
         if (accept) begin
            mask_q     <= req_mask;
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
         end
         mem_ce_n  <= ~lane_active;
         mem_oe_n  <= (st_d != ST_RACCESS);
         mem_we_n  <= (st_d != ST_WPULSE);
         mem_bs_n  <= bs_n_d;
         mem_dq_oe <= (st_d == ST_WPULSE) || (st_d == ST_WHOLD);
         rd_valid  <= (st_q == ST_RACCESS) && ph_exp;
         if ((st_q == ST_RACCESS) && ph_exp) rd_data <= mem_dq_in;
      end
   end

   // R4
   no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   // R2
   write_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_ce_n && !(&mem_bs_n)));

   // R3
   write_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |=> ($stable(mem_addr) && $stable(mem_dq_out) && $stable(mem_bs_n)));

   // R6
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   // R7
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/sram_strobe_ctrl_bench.sv
module sram_strobe_ctrl_bench;

   localparam int CLK_PS     = 4000;
   localparam int EXP_FLOAT  = (5000 + CLK_PS - 1) / CLK_PS;
   localparam int EXP_PULSE  = (7000 + CLK_PS - 1) / CLK_PS;
   localparam int EXP_SD     = (5000 + CLK_PS - 1) / CLK_PS;
   localparam int EXP_AW     = (9000 + CLK_PS - 1) / CLK_PS;
   localparam int EXP_ACCESS = (10000 + CLK_PS - 1) / CLK_PS;
   localparam int EXP_CYCLE  = (10000 + CLK_PS - 1) / CLK_PS;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [14:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_mask = '0;
   logic        rd_valid;
   logic [15:0] rd_data;
   logic [14:0] mem_addr;
   logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [1:0]  mem_bs_n;
   logic [15:0] mem_dq_out;
   logic [15:0] dq_model;

   logic [15:0] model [0:255];
   logic [15:0] gold  [0:255];

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [1:0] cur_mask = 2'b00;
   int we_falls = 0;

   always #2ns clk = ~clk;

   sram_strobe_ctrl u_sram_strobe_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_bs_n(mem_bs_n), .mem_dq_out(mem_dq_out),
      .mem_dq_oe(mem_dq_oe), .mem_dq_in(dq_model)
   );

   assign dq_model = (!mem_ce_n && !mem_oe_n && mem_we_n)
                   ? { (!mem_bs_n[1] ? model[mem_addr[7:0]][15:8] : 8'hEE),
                       (!mem_bs_n[0] ? model[mem_addr[7:0]][7:0]  : 8'hEE) }
                   : 16'hDEAD;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // pin monitor, sampled away from the active edge
   int we_run = 0, addr_run = 0, data_run = 0, oe_high_run = 100;
   logic        prev_we_n = 1'b1, prev_ce_n = 1'b1, prev_dq_oe = 1'b0;
   logic [14:0] prev_addr = '0;
   logic [15:0] prev_dq = '0;
   logic [1:0]  prev_bs = 2'b11;

   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_dq_oe && !prev_dq_oe)
            chk(oe_high_run >= EXP_FLOAT && mem_oe_n, "R4 float before drive",
                oe_high_run, EXP_FLOAT);
         if (mem_dq_oe && !mem_oe_n)
            chk(1'b0, "R4 bus contention", {31'd0, mem_oe_n}, 1);
         if (!mem_we_n && prev_we_n) begin
            we_falls++;
            chk(mem_bs_n == ~cur_mask && !mem_ce_n, "R2 strobe mapping",
                {mem_ce_n, mem_bs_n}, {1'b0, ~cur_mask});
         end
         if (mem_we_n && !prev_we_n) begin
            chk(we_run >= EXP_PULSE, "R2 write pulse width", we_run, EXP_PULSE);
            chk(addr_run >= EXP_AW, "R3 address valid to write end", addr_run, EXP_AW);
            chk(data_run >= EXP_SD, "R3 data setup to write end", data_run, EXP_SD);
            chk(!mem_ce_n && mem_dq_oe && mem_addr == prev_addr && mem_dq_out == prev_dq
                && mem_bs_n == prev_bs, "R3 hold after write end",
                {mem_ce_n, mem_dq_oe, mem_bs_n}, {1'b0, 1'b1, prev_bs});
            if (!mem_ce_n && mem_dq_oe) begin
               if (!mem_bs_n[0]) model[mem_addr[7:0]][7:0]  = mem_dq_out[7:0];
               if (!mem_bs_n[1]) model[mem_addr[7:0]][15:8] = mem_dq_out[15:8];
            end
         end
         we_run      = !mem_we_n ? we_run + 1 : 0;
         addr_run    = !mem_ce_n ? ((!prev_ce_n && mem_addr == prev_addr) ? addr_run + 1 : 1) : 0;
         data_run    = mem_dq_oe ? ((prev_dq_oe && mem_dq_out == prev_dq) ? data_run + 1 : 1) : 0;
         oe_high_run = mem_oe_n ? oe_high_run + 1 : 0;
      end
      prev_we_n  = mem_we_n;
      prev_ce_n  = mem_ce_n;
      prev_dq_oe = mem_dq_oe;
      prev_addr  = mem_addr;
      prev_dq    = mem_dq_out;
      prev_bs    = mem_bs_n;
   end

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   task automatic do_write(input logic [14:0] a, input logic [15:0] d, input logic [1:0] m);
      int busy = 0;
      int falls0;
      int exp_busy;
      while (!req_ready) @(negedge clk);
      cur_mask  = m;
      falls0    = we_falls;
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_mask = m;
      @(negedge clk);
      req_valid = 1'b0;
      while (!req_ready) begin busy++; @(negedge clk); end
      // phases: float, pulse covering setup rules, one hold cycle
      exp_busy = (m == 2'b00) ? EXP_CYCLE
               : imax(EXP_CYCLE, EXP_FLOAT + imax(imax(EXP_PULSE, EXP_SD), EXP_AW - EXP_FLOAT) + 1);
      chk(busy == exp_busy, "R7 write busy time", busy, exp_busy);
      if (m == 2'b00)
         chk(we_falls == falls0, "R5 zero mask no pulse", we_falls - falls0, 0);
      else
         chk(we_falls == falls0 + 1, "R2 single write pulse", we_falls - falls0, 1);
      if (m[0]) gold[a[7:0]][7:0]  = d[7:0];
      if (m[1]) gold[a[7:0]][15:8] = d[15:8];
   endtask

   task automatic do_read(input logic [14:0] a);
      int busy = 0;
      bit counting = 1'b1;
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_mask = 2'b10;
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 1; k <= EXP_ACCESS + 2; k++) begin
         if (k == 1)
            chk(!mem_ce_n && !mem_oe_n && mem_we_n && mem_bs_n == 2'b00 && !mem_dq_oe,
                "R6 read strobes", {mem_ce_n, mem_oe_n, mem_we_n, mem_bs_n, mem_dq_oe},
                6'b001000);
         if (k == EXP_ACCESS)
            chk(!rd_valid, "R6 valid not early", rd_valid, 0);
         if (k == EXP_ACCESS + 1) begin
            chk(rd_valid, "R6 valid on time", rd_valid, 1);
            chk(rd_data == gold[a[7:0]], "R8 read data", rd_data, gold[a[7:0]]);
         end
         if (k == EXP_ACCESS + 2)
            chk(!rd_valid, "R6 valid one cycle", rd_valid, 0);
         if (counting && !req_ready) busy++;
         else counting = 1'b0;
         if (k < EXP_ACCESS + 2) @(negedge clk);
      end
      chk(busy == imax(EXP_CYCLE, EXP_ACCESS), "R7 read busy time", busy,
          imax(EXP_CYCLE, EXP_ACCESS));
   endtask

   function automatic logic [15:0] pat(input int i, input int pass);
      return 16'((i * 16'h1357) ^ (pass * 16'h9A3C) ^ 16'h0F0F);
   endfunction

   initial begin
      for (int i = 0; i < 256; i++) begin model[i] = 16'h0000; gold[i] = 16'h0000; end
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(req_ready && mem_ce_n && mem_oe_n && mem_we_n && mem_bs_n == 2'b11
          && !mem_dq_oe && !rd_valid, "R1 reset state",
          {req_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_bs_n, mem_dq_oe, rd_valid},
          8'b11111100);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && mem_ce_n && mem_we_n && !mem_dq_oe, "R1 idle after release",
          {req_ready, mem_ce_n, mem_we_n, mem_dq_oe}, 4'b1110);

      for (int i = 0; i < 64; i++) do_write(15'(i), pat(i, 1), 2'b11);
      for (int i = 0; i < 64; i++) do_read(15'(i));
      // every mask value, zero mask included (R5)
      for (int i = 0; i < 64; i++) do_write(15'(i), pat(i, 2), 2'(i % 4));
      for (int i = 0; i < 64; i++) do_read(15'(i));
      // top of the address space, read then write back to back
      for (int i = 0; i < 16; i++) begin
         do_write(15'h7FF0 + 15'(i), pat(i, 3), 2'b11);
         do_read(15'h7FF0 + 15'(i));
         do_write(15'h7FF0 + 15'(i), pat(i, 4), 2'((i % 3) + 1));
         do_read(15'h7FF0 + 15'(i));
         do_write(15'h7FF0 + 15'(i), 16'hFFFF, 2'b00);
         do_read(15'h7FF0 + 15'(i));
      end
      repeat (4) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule